// File: doc/BRIEF.md
# Serially Programmed Twelve-Channel Trim Code Bank

This block is the digital core of a bank of twelve 8-bit trim converters. A three-wire serial port carries the traffic. It has an active-low select, a serial clock and a data line. While select is low, the block shifts one bit in on each rising edge of the serial clock, most significant bit first. When select goes high again, the most recent 12 bits are taken as one frame. The upper four bits name a channel and the lower eight bits give its new code. The named channel's holding register takes the code, and every other channel keeps its value.

The twelve codes leave the block as one flat vector, with channel k in bits [8k+7:8k]. A separate power-down request passes through a register to a status output, which the analog side uses to switch off reference current. Power-down never touches the stored codes. An asynchronous active-low preset loads every channel with the midscale code 0x80 and also serves as the block's reset. The three serial pins are oversampled by the system clock through synchronisers. The serial clock must therefore stay in each level for at least three system clock cycles.

Top module: `trim_bank_top`

## Requirements
- R1: While `preset_n` is low, every channel code equals 0x80 without waiting for a clock edge, `pd_o` is 0, and the frame shift register is cleared.
- R2: A frame is shifted in MSB first. When select is released, frame bits [11:8] are the address and bits [7:0] are the code. Address value a (0 to 11) writes the code into channel a, which sits at `ch_code_o[8a+7:8a]`.
- R3: Channel codes change only after a rising edge of `sel_n_i`. A fully shifted frame still held with select low leaves every channel unchanged.
- R4: A frame whose address is 12 to 15 leaves all twelve channel codes unchanged.
- R5: A frame changes at most one channel, and the channels it does not address keep their codes.
- R6: The shift register is cleared when select falls. A frame of fewer than 12 clocks is therefore padded with zeros at the top: 8 clocks carrying value v write v to channel 0.
- R7: Serial clock edges and data while `sel_n_i` is high have no effect on any channel.
- R8: A frame of more than 12 clocks uses only the last 12 bits shifted in.
- R9: `pd_o` equals the value `pd_req_i` had at the previous rising edge of `clk`.
- R10: Raising or lowering `pd_req_i` leaves every channel code unchanged, and frames sent during power-down are still written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| preset_n | input | 1 | Asynchronous active-low preset to midscale, also the block reset |
| sck_i | input | 1 | Serial clock, data taken on its rising edge |
| sel_n_i | input | 1 | Active-low select; its rising edge commits the frame |
| sdi_i | input | 1 | Serial data, MSB first |
| pd_req_i | input | 1 | Power-down request |
| ch_code_o | output | 96 | Twelve 8-bit channel codes, channel k at bits [8k+7:8k] |
| pd_o | output | 1 | Registered power-down status |

## Verification
Frames go to the first, the last and a middle channel with codes 0x00, 0xFF and mixed patterns. This shows that address bits and data bits land in the right slice and that the neighbouring channels keep their codes. Frames to the unused addresses 12 and 15, a frame held without releasing select, and clocks toggled while deselected all leave the twelve codes unchanged. Together these separate a write that happens on commit from a write that leaks through at some other time. Frames of 8 and 16 clocks show the clearing at select fall and the keep-last-12-bits rule. Power-down is toggled around a write to show that status and codes are independent, and a preset between clock edges shows that it acts asynchronously.

// File: rtl/trim_bank_pkg.sv
package trim_bank_pkg;
    parameter int          DEF_NUM_CH      = 12;
    parameter int          DEF_ADDR_W      = 4;
    parameter int          DEF_CODE_W      = 8;
    parameter int          DEF_SYNC_STAGES = 2;
    parameter logic [7:0]  DEF_PRESET_CODE = 8'h80;

    // State of the power-down status path
    typedef struct packed {
        logic pd;
    } pd_state_t;
endpackage

// File: rtl/trim_serial_rx.sv
module trim_serial_rx #(
    parameter  int ADDR_W      = trim_bank_pkg::DEF_ADDR_W,
    parameter  int CODE_W      = trim_bank_pkg::DEF_CODE_W,
    parameter  int SYNC_STAGES = trim_bank_pkg::DEF_SYNC_STAGES,
    localparam int FRAME_W     = ADDR_W + CODE_W
) (
    input  logic               clk,
    input  logic               preset_n,
    input  logic               sck_i,
    input  logic               sel_n_i,
    input  logic               sdi_i,
    output logic               commit_o,
    output logic [FRAME_W-1:0] frame_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sck_pipe;
        logic [SYNC_STAGES-1:0] sel_pipe;
        logic [SYNC_STAGES-1:0] sdi_pipe;
        logic                   sck_prev;
        logic                   sel_prev;
        logic [FRAME_W-1:0]     shift;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic sck_now, sel_now, sdi_now;

    always_comb begin
        sck_now = st_q.sck_pipe[SYNC_STAGES-1];
        sel_now = st_q.sel_pipe[SYNC_STAGES-1];
        sdi_now = st_q.sdi_pipe[SYNC_STAGES-1];

        st_d          = st_q;
        st_d.sck_pipe = {st_q.sck_pipe[SYNC_STAGES-2:0], sck_i};
        st_d.sel_pipe = {st_q.sel_pipe[SYNC_STAGES-2:0], sel_n_i};
        st_d.sdi_pipe = {st_q.sdi_pipe[SYNC_STAGES-2:0], sdi_i};
        st_d.sck_prev = sck_now;
        st_d.sel_prev = sel_now;

        if (!sel_now && st_q.sel_prev) begin
            // select just fell: start a fresh frame
            st_d.shift = '0;
        end else if (!sel_now && sck_now && !st_q.sck_prev) begin
            st_d.shift = {st_q.shift[FRAME_W-2:0], sdi_now};
        end
    end

    always_ff @(posedge clk or negedge preset_n) begin
        if (!preset_n) begin
            st_q.sck_pipe <= '0;
            st_q.sel_pipe <= '1;
            st_q.sdi_pipe <= '0;
            st_q.sck_prev <= 1'b0;
            st_q.sel_prev <= 1'b1;
            st_q.shift    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_o = sel_now && !st_q.sel_prev;
    assign frame_o  = st_q.shift;
endmodule

// File: rtl/trim_chan_bank.sv
module trim_chan_bank #(
    parameter  int         NUM_CH      = trim_bank_pkg::DEF_NUM_CH,
    parameter  int         ADDR_W      = trim_bank_pkg::DEF_ADDR_W,
    parameter  int         CODE_W      = trim_bank_pkg::DEF_CODE_W,
    parameter  logic [CODE_W-1:0] PRESET_CODE = trim_bank_pkg::DEF_PRESET_CODE,
    localparam int         FRAME_W     = ADDR_W + CODE_W
) (
    input  logic                     clk,
    input  logic                     preset_n,
    input  logic                     commit_i,
    input  logic [FRAME_W-1:0]       frame_i,
    output logic [NUM_CH*CODE_W-1:0] codes_o
);
    typedef struct packed {
        logic [NUM_CH-1:0][CODE_W-1:0] codes;
    } bank_state_t;

    bank_state_t       st_d, st_q;
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] code;
    logic [NUM_CH-1:0] wr_en;

    assign addr = frame_i[FRAME_W-1 -: ADDR_W];
    assign code = frame_i[CODE_W-1:0];

    // One address comparator per channel; addresses past the last channel match none
    for (genvar k = 0; k < NUM_CH; k++) begin : g_dec
        assign wr_en[k] = commit_i && (addr == ADDR_W'(k));
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_CH; k++) begin
            if (wr_en[k]) begin
                st_d.codes[k] = code;
            end
        end
    end

    always_ff @(posedge clk or negedge preset_n) begin
        if (!preset_n) begin
            for (int k = 0; k < NUM_CH; k++) begin
                st_q.codes[k] <= PRESET_CODE;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign codes_o = st_q.codes;
endmodule

// File: rtl/trim_bank_top.sv
module trim_bank_top #(
    parameter  int         NUM_CH      = trim_bank_pkg::DEF_NUM_CH,
    parameter  int         ADDR_W      = trim_bank_pkg::DEF_ADDR_W,
    parameter  int         CODE_W      = trim_bank_pkg::DEF_CODE_W,
    parameter  int         SYNC_STAGES = trim_bank_pkg::DEF_SYNC_STAGES,
    parameter  logic [CODE_W-1:0] PRESET_CODE = trim_bank_pkg::DEF_PRESET_CODE,
    localparam int         FRAME_W     = ADDR_W + CODE_W
) (
    input  logic                     clk,
    input  logic                     preset_n,
    input  logic                     sck_i,
    input  logic                     sel_n_i,
    input  logic                     sdi_i,
    input  logic                     pd_req_i,
    output logic [NUM_CH*CODE_W-1:0] ch_code_o,
    output logic                     pd_o
);
    logic               commit_w;
    logic [FRAME_W-1:0] frame_w;

    trim_bank_pkg::pd_state_t pd_d, pd_q;

    trim_serial_rx #(
        .ADDR_W      (ADDR_W),
        .CODE_W      (CODE_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_rx (
        .clk      (clk),
        .preset_n (preset_n),
        .sck_i    (sck_i),
        .sel_n_i  (sel_n_i),
        .sdi_i    (sdi_i),
        .commit_o (commit_w),
        .frame_o  (frame_w)
    );

    trim_chan_bank #(
        .NUM_CH      (NUM_CH),
        .ADDR_W      (ADDR_W),
        .CODE_W      (CODE_W),
        .PRESET_CODE (PRESET_CODE)
    ) u_bank (
        .clk      (clk),
        .preset_n (preset_n),
        .commit_i (commit_w),
        .frame_i  (frame_w),
        .codes_o  (ch_code_o)
    );

    // Power-down status: registered pass-through, independent of the serial path
    always_comb begin
        pd_d    = pd_q;
        pd_d.pd = pd_req_i;
    end

    always_ff @(posedge clk or negedge preset_n) begin
        if (!preset_n) begin
            pd_q <= '0;
        end else begin
            pd_q <= pd_d;
        end
    end

    assign pd_o = pd_q.pd;
endmodule

// File: rtl/trim_bank_chk.sv
module trim_bank_chk #(
    parameter  int                NUM_CH      = 12,
    parameter  int                ADDR_W      = 4,
    parameter  int                CODE_W      = 8,
    parameter  logic [CODE_W-1:0] PRESET_CODE = 8'h80,
    localparam int                FRAME_W     = ADDR_W + CODE_W
) (
    input logic                     clk,
    input logic                     preset_n,
    input logic                     commit,
    input logic [FRAME_W-1:0]       frame,
    input logic [NUM_CH*CODE_W-1:0] ch_code,
    input logic                     pd_req,
    input logic                     pd
);
    logic [NUM_CH*CODE_W-1:0] prev_q;
    logic                     exp_valid_q;
    logic [ADDR_W-1:0]        exp_idx_q;
    logic [CODE_W-1:0]        exp_code_q;
    logic [NUM_CH-1:0]        changed;
    logic [ADDR_W-1:0]        fr_addr;
    logic                     fr_in_range;
    logic [CODE_W-1:0]        tgt_code;

    assign fr_addr     = frame[FRAME_W-1 -: ADDR_W];
    assign fr_in_range = int'(fr_addr) < NUM_CH;
    assign tgt_code    = ch_code[int'(exp_idx_q)*CODE_W +: CODE_W];

    for (genvar k = 0; k < NUM_CH; k++) begin : g_cmp
        assign changed[k] = prev_q[k*CODE_W +: CODE_W] != ch_code[k*CODE_W +: CODE_W];
    end

    always_ff @(posedge clk or negedge preset_n) begin
        if (!preset_n) begin
            prev_q      <= {NUM_CH{PRESET_CODE}};
            exp_valid_q <= 1'b0;
            exp_idx_q   <= '0;
            exp_code_q  <= '0;
        end else begin
            prev_q      <= ch_code;
            exp_valid_q <= commit && fr_in_range;
            exp_idx_q   <= fr_addr;
            exp_code_q  <= frame[CODE_W-1:0];
        end
    end

    assert_write_value_R2: assert property (@(posedge clk) disable iff (!preset_n)
        exp_valid_q |-> (tgt_code == exp_code_q));

    // also covers R10: power-down changes alone never move a code
    assert_no_write_without_commit_R3: assert property (@(posedge clk) disable iff (!preset_n)
        !commit |=> $stable(ch_code));

    assert_high_addr_ignored_R4: assert property (@(posedge clk) disable iff (!preset_n)
        (commit && !fr_in_range) |=> $stable(ch_code));

    assert_single_channel_R5: assert property (@(posedge clk) disable iff (!preset_n)
        $onehot0(changed));

    assert_pd_follows_R9: assert property (@(posedge clk) disable iff (!preset_n)
        $past(preset_n) |-> (pd == $past(pd_req)));
endmodule

bind trim_bank_top trim_bank_chk #(
    .NUM_CH      (NUM_CH),
    .ADDR_W      (ADDR_W),
    .CODE_W      (CODE_W),
    .PRESET_CODE (PRESET_CODE)
) u_chk (
    .clk      (clk),
    .preset_n (preset_n),
    .commit   (commit_w),
    .frame    (frame_w),
    .ch_code  (ch_code_o),
    .pd_req   (pd_req_i),
    .pd       (pd_o)
);

// File: tb/sim_trim_bank_top.sv
`timescale 1ns/1ps
module sim_trim_bank_top;
    localparam int NCH = 12;
    localparam int CW  = 8;
    localparam int HALF = 4;   // system clocks per serial half period

    logic clk = 1'b0;
    logic preset_n = 1'b0;
    logic sck = 1'b0, sel_n = 1'b1, sdi = 1'b0, pd_req = 1'b0;
    logic [NCH*CW-1:0] ch_code;
    logic pd;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [CW-1:0] model [NCH];

    always #5 clk = ~clk;

    trim_bank_top u0 (
        .clk       (clk),
        .preset_n  (preset_n),
        .sck_i     (sck),
        .sel_n_i   (sel_n),
        .sdi_i     (sdi),
        .pd_req_i  (pd_req),
        .ch_code_o (ch_code),
        .pd_o      (pd)
    );

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        int bad = -1;
        n_chk++;
        for (int k = 0; k < NCH; k++)
            if (bad < 0 && ch_code[k*CW +: CW] !== model[k]) bad = k;
        if (bad >= 0) begin
            n_fail++;
            $display("FAIL %s: channel %0d actual %0h expected %0h",
                     req, bad, ch_code[bad*CW +: CW], model[bad]);
        end
    endtask

    task automatic model_preset();
        for (int k = 0; k < NCH; k++) model[k] = 8'h80;
    endtask

    // Shift nbits of 'bits' MSB first; release select only if 'release_sel'
    task automatic shift_bits(input int nbits, input logic [31:0] bits, input bit release_sel);
        sel_n = 1'b0;
        wait_clk(HALF);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdi = bits[i];
            sck = 1'b0; wait_clk(HALF);
            sck = 1'b1; wait_clk(HALF);
        end
        sck = 1'b0; wait_clk(HALF);
        if (release_sel) begin
            sel_n = 1'b1;
            wait_clk(8);
        end
    endtask

    task automatic write_ch(input int a, input logic [7:0] v);
        shift_bits(12, {20'd0, 4'(a), v}, 1'b1);
        if (a < NCH) model[a] = v;
    endtask

    task automatic t_reset();
        model_preset();
        check_all("R1 preset state");
        chk("R1 pd after preset", pd, 0);
    endtask

    task automatic t_basic();
        write_ch(0, 8'h3C);  check_all("R2 write ch0");
        write_ch(11, 8'hFF); check_all("R2 write ch11");
        write_ch(5, 8'h00);  check_all("R5 write ch5, others hold");
        write_ch(5, 8'hA6);  check_all("R2 rewrite ch5");
    endtask

    task automatic t_hold();
        shift_bits(12, {20'd0, 4'd3, 8'h5A}, 1'b0);
        wait_clk(10);
        check_all("R3 no write while select low");
        sel_n = 1'b1;
        wait_clk(8);
        model[3] = 8'h5A;
        check_all("R3 write after select release");
    endtask

    task automatic t_high_addr();
        write_ch(12, 8'h11); check_all("R4 address 12 ignored");
        write_ch(15, 8'h22); check_all("R4 address 15 ignored");
    endtask

    task automatic t_idle_clocks();
        for (int i = 0; i < 20; i++) begin
            sdi = i[0];
            sck = 1'b1; wait_clk(HALF);
            sck = 1'b0; wait_clk(HALF);
        end
        wait_clk(8);
        check_all("R7 clocks while deselected");
    endtask

    task automatic t_short();
        shift_bits(8, 32'hA5, 1'b1);
        model[0] = 8'hA5;
        check_all("R6 8-clock frame zero padded to ch0");
    endtask

    task automatic t_long();
        shift_bits(16, 32'h9477, 1'b1);
        model[4] = 8'h77;
        check_all("R8 16-clock frame keeps last 12 bits");
    endtask

    task automatic t_shutdown();
        pd_req = 1'b1;
        wait_clk(1);
        chk("R9 pd one cycle after request", pd, 1);
        wait_clk(4);
        check_all("R10 codes kept in power-down");
        write_ch(7, 8'h11);
        check_all("R10 write during power-down");
        chk("R9 pd held", pd, 1);
        pd_req = 1'b0;
        wait_clk(1);
        chk("R9 pd released", pd, 0);
        check_all("R10 codes kept after power-down");
    endtask

    task automatic t_async_preset();
        @(negedge clk);
        #2 preset_n = 1'b0;
        #1;
        model_preset();
        check_all("R1 preset acts between clock edges");
        wait_clk(2);
        preset_n = 1'b1;
        wait_clk(2);
        write_ch(9, 8'h01);
        check_all("R1 writes work after preset");
    endtask

    initial begin
        wait_clk(5);
        preset_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_basic();
        t_hold();
        t_high_addr();
        t_idle_clocks();
        t_short();
        t_long();
        t_shutdown();
        t_async_preset();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule